// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is a single-byte SPI master peripheral. Software programs it over a small 32-bit register bus. The bus has an address, a write strobe, a read strobe, write data and read data. Read data is a combinational function of the address, and a read has its side effect at the clock edge where the read strobe is high. A write to the transmit register starts one full-duplex exchange of eight bits, MSB first. The byte captured from MISO is then held in the receive register until software fetches it.

The serial clock comes from a two-stage divider. A coarse prescaler selects 16 or 128, and a fine 5-bit code N multiplies the half period by N+1. Clock polarity and clock phase are independent control bits, so all four SPI modes are available. The clock idles at the polarity level between frames. The chip-select line is not sequenced by hardware. It simply follows one bit of the system control register, so software can hold it low across several bytes. Two status bits tell software when the transmit path is free and when a received byte is waiting.

Top module: `spim_top`

## Requirements
- R1: After reset the control, status, transmit, receive and scratch registers read 0, the system control register reads 0x40, cs_n is 1 and sck is 0.
- R2: The offsets are control 0x00, status 0x04, system control 0x08, transmit 0x0C, receive 0x10 and scratch 0x14. The scratch register keeps any 32-bit value written to it and has no other effect. Every other offset reads 0.
- R3: Control bits [4:0] hold N, and control bit 5 selects the prescaler P (1 gives 128, 0 gives 16). During a frame, sck toggles every P*(N+1) clock cycles, so one frame spans 16 toggles.
- R4: Control bit 6 is CPOL and sets the idle level of sck. Control bit 7 is CPHA. With CPHA 0, MISO is sampled and MOSI is stable on the leading edges, and MOSI changes on the trailing edges. With CPHA 1, MOSI changes on the leading edges and MISO is sampled on the trailing edges. Bits are sent and received MSB first.
- R5: A write to 0x0C while status bit 0 is 0 starts an exchange of that byte. Status bit 0 reads 1 from the next cycle until the frame ends. A write to 0x0C while status bit 0 is 1 is ignored. The transmit register reads back the byte being sent.
- R6: At the end of a frame, status bit 2 (receive full) is set and the byte shifted in from MISO is readable at 0x10.
- R7: A read of 0x10 clears status bit 2. A frame that completes before the previous byte was read overwrites the receive register.
- R8: A write to the status register with bit 2 equal to 0 clears the receive-full flag. A write with bit 2 equal to 1 leaves it unchanged.
- R9: cs_n is driven by system control bit 6: 1 drives it high, 0 drives it low. Writing 0x21 therefore drives cs_n low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (8) | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe (side effects only) |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for bus_addr |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |

## Verification
The bench runs a behavioural slave in every SPI mode. The slave checks which edge carries each bit, so a design with swapped phase handling would corrupt both directions. It times the last sck interval for both prescalers and several N values, which catches an off-by-one divider or a prescaler choice taken from the wrong bit. It writes the transmit register mid-frame: a design that restarted or reloaded would show extra edges or a changed byte at the slave. Further scenarios cover overwrite without a read, the two forms of status write and cs_n after the value 0x21, where a design that decoded the wrong bit would leave the line high.

// File: rtl/spim_pkg.sv
package spim_pkg;

   localparam logic [7:0] OFS_CTRL = 8'h00;
   localparam logic [7:0] OFS_STAT = 8'h04;
   localparam logic [7:0] OFS_SYS  = 8'h08;
   localparam logic [7:0] OFS_TXB  = 8'h0C;
   localparam logic [7:0] OFS_RXB  = 8'h10;
   localparam logic [7:0] OFS_AUX  = 8'h14;

   localparam int FRAME_BITS = 8;
   localparam int EDGES      = 2 * FRAME_BITS;
   localparam int EDGE_W     = $clog2(EDGES);
   localparam int DIV_W      = 5;

   localparam logic [7:0] SYS_RESET = 8'h40;
   localparam int SYS_CS_BIT  = 6;
   localparam int STAT_BSY    = 0;
   localparam int STAT_RXF    = 2;

   typedef struct packed {
      logic             cpha;
      logic             cpol;
      logic             slow;
      logic [DIV_W-1:0] div;
   } ctrl_t;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_CTRL,
      SEL_STAT,
      SEL_SYS,
      SEL_TXB,
      SEL_RXB,
      SEL_AUX
   } sel_e;

   function automatic sel_e decode_ofs(input logic [7:0] a);
      sel_e s;
      case (a)
         OFS_CTRL: s = SEL_CTRL;
         OFS_STAT: s = SEL_STAT;
         OFS_SYS:  s = SEL_SYS;
         OFS_TXB:  s = SEL_TXB;
         OFS_RXB:  s = SEL_RXB;
         OFS_AUX:  s = SEL_AUX;
         default:  s = SEL_NONE;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/spim_baud.sv
module spim_baud
   import spim_pkg::*;
#(
   parameter int PRE_LO = 16,
   parameter int PRE_HI = 128
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             run,
   input  logic             slow,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);

   localparam int PW = $clog2(PRE_HI);
   localparam logic [PW-1:0] TOP_LO = PW'(PRE_LO - 1);
   localparam logic [PW-1:0] TOP_HI = PW'(PRE_HI - 1);

   initial begin
      if (PRE_LO < 2 || PRE_HI <= PRE_LO)
         $fatal(1, "spim_baud: prescaler values out of range");
   end

   logic [PW-1:0]    pre_cnt;
   logic [DIV_W-1:0] div_cnt;
   logic [DIV_W-1:0] div_q;
   logic             slow_q;
   logic [PW-1:0]    pre_top;
   logic             pre_wrap;
   logic             div_wrap;

   always_comb begin
      pre_top  = slow_q ? TOP_HI : TOP_LO;
      pre_wrap = (pre_cnt == pre_top);
      div_wrap = (div_cnt == div_q);
      tick     = run & pre_wrap & div_wrap;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_cnt <= '0;
         div_cnt <= '0;
         div_q   <= '0;
         slow_q  <= 1'b0;
      end else if (start) begin
         pre_cnt <= '0;
         div_cnt <= '0;
         div_q   <= div;
         slow_q  <= slow;
      end else if (run) begin
         if (pre_wrap) begin
            pre_cnt <= '0;
            div_cnt <= div_wrap ? '0 : div_cnt + 1'b1;
         end else begin
            pre_cnt <= pre_cnt + 1'b1;
         end
      end
   end

endmodule

// File: rtl/spim_shifter.sv
module spim_shifter
   import spim_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic [FRAME_BITS-1:0] tx_byte,
   input  logic                  cpol,
   input  logic                  cpha,
   input  logic                  tick,
   input  logic                  miso,
   output logic                  busy,
   output logic                  done,
   output logic                  sck,
   output logic                  mosi,
   output logic [FRAME_BITS-1:0] rx_word
);

   initial begin
      if (SYNC_STAGES < 0 || SYNC_STAGES > 3)
         $fatal(1, "spim_shifter: SYNC_STAGES must be 0..3");
   end

   logic miso_s;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign miso_s = miso;
      end else if (SYNC_STAGES == 1) begin : g_sync1
         logic s1_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s1_q <= 1'b0;
            else        s1_q <= miso;
         end
         assign miso_s = s1_q;
      end else begin : g_syncn
         logic [SYNC_STAGES-1:0] sn_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sn_q <= '0;
            else        sn_q <= {sn_q[SYNC_STAGES-2:0], miso};
         end
         assign miso_s = sn_q[SYNC_STAGES-1];
      end
   endgenerate

   logic                  busy_q;
   logic                  sck_q;
   logic                  mosi_q;
   logic                  cpha_q;
   logic [EDGE_W-1:0]     edge_cnt;
   logic [FRAME_BITS-1:0] txsh;
   logic [FRAME_BITS-1:0] rxsh;

   logic step, last, lead, smp, drv;
   logic [FRAME_BITS-1:0] rx_next;

   always_comb begin
      step    = busy_q & tick;
      last    = (edge_cnt == EDGE_W'(EDGES - 1));
      lead    = ~edge_cnt[0];
      smp     = lead ^ cpha_q;
      drv     = ~smp & ~last;
      rx_next = smp ? {rxsh[FRAME_BITS-2:0], miso_s} : rxsh;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         sck_q    <= 1'b0;
         mosi_q   <= 1'b0;
         cpha_q   <= 1'b0;
         edge_cnt <= '0;
         txsh     <= '0;
         rxsh     <= '0;
      end else if (start) begin
         busy_q   <= 1'b1;
         sck_q    <= cpol;
         cpha_q   <= cpha;
         edge_cnt <= '0;
         rxsh     <= '0;
         if (cpha) begin
            txsh <= tx_byte;
         end else begin
            mosi_q <= tx_byte[FRAME_BITS-1];
            txsh   <= {tx_byte[FRAME_BITS-2:0], 1'b0};
         end
      end else if (step) begin
         sck_q    <= ~sck_q;
         edge_cnt <= edge_cnt + 1'b1;
         rxsh     <= rx_next;
         if (drv) begin
            mosi_q <= txsh[FRAME_BITS-1];
            txsh   <= {txsh[FRAME_BITS-2:0], 1'b0};
         end
         if (last) busy_q <= 1'b0;
      end
   end

   assign busy    = busy_q;
   assign done    = step & last;
   assign rx_word = rx_next;
   assign sck     = busy_q ? sck_q : cpol;
   assign mosi    = mosi_q;

endmodule

// File: rtl/spim_regfile.sv
module spim_regfile
   import spim_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic                  bus_we,
   input  logic                  bus_re,
   input  logic [DATA_W-1:0]     bus_wdata,
   output logic [DATA_W-1:0]     bus_rdata,
   input  logic                  busy,
   input  logic                  done,
   input  logic [FRAME_BITS-1:0] rx_word,
   output ctrl_t                 ctrl,
   output logic                  start,
   output logic [FRAME_BITS-1:0] tx_byte,
   output logic                  rxf,
   output logic                  cs_n
);

   initial begin
      if (ADDR_W < 8) $fatal(1, "spim_regfile: ADDR_W must be at least 8");
      if (DATA_W < 8) $fatal(1, "spim_regfile: DATA_W must be at least 8");
   end

   logic in_page;
   logic [7:0] a8;

   generate
      if (ADDR_W == 8) begin : g_flat
         assign in_page = 1'b1;
         assign a8      = bus_addr;
      end else begin : g_wide
         assign in_page = (bus_addr[ADDR_W-1:8] == '0);
         assign a8      = bus_addr[7:0];
      end
   endgenerate

   sel_e sel;
   assign sel = in_page ? decode_ofs(a8) : SEL_NONE;

   ctrl_t                 ctrl_q;
   logic [7:0]            sys_q;
   logic [FRAME_BITS-1:0] tx_q;
   logic [FRAME_BITS-1:0] rx_q;
   logic                  rxf_q;
   logic [DATA_W-1:0]     aux_q;

   logic wr_ctrl, wr_stat, wr_sys, wr_aux, rd_rx, clr_rxf;

   always_comb begin
      wr_ctrl = bus_we & (sel == SEL_CTRL);
      wr_stat = bus_we & (sel == SEL_STAT);
      wr_sys  = bus_we & (sel == SEL_SYS);
      wr_aux  = bus_we & (sel == SEL_AUX);
      start   = bus_we & (sel == SEL_TXB) & ~busy;
      rd_rx   = bus_re & (sel == SEL_RXB);
      clr_rxf = rd_rx | (wr_stat & ~bus_wdata[STAT_RXF]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         sys_q  <= SYS_RESET;
         tx_q   <= '0;
         rx_q   <= '0;
         rxf_q  <= 1'b0;
         aux_q  <= '0;
      end else begin
         if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata[7:0]);
         if (wr_sys)  sys_q  <= bus_wdata[7:0];
         if (wr_aux)  aux_q  <= bus_wdata;
         if (start)   tx_q   <= bus_wdata[FRAME_BITS-1:0];
         if (done) begin
            rx_q  <= rx_word;
            rxf_q <= 1'b1;
         end else if (clr_rxf) begin
            rxf_q <= 1'b0;
         end
      end
   end

   logic [7:0] stat_v;
   always_comb begin
      stat_v           = '0;
      stat_v[STAT_BSY] = busy;
      stat_v[STAT_RXF] = rxf_q;
   end

   always_comb begin
      case (sel)
         SEL_CTRL: bus_rdata = DATA_W'(ctrl_q);
         SEL_STAT: bus_rdata = DATA_W'(stat_v);
         SEL_SYS:  bus_rdata = DATA_W'(sys_q);
         SEL_TXB:  bus_rdata = DATA_W'(tx_q);
         SEL_RXB:  bus_rdata = DATA_W'(rx_q);
         SEL_AUX:  bus_rdata = aux_q;
         default:  bus_rdata = '0;
      endcase
   end

   assign ctrl    = ctrl_q;
   assign tx_byte = tx_q;
   assign rxf     = rxf_q;
   assign cs_n    = sys_q[SYS_CS_BIT];

endmodule

// File: rtl/spim_top.sv
module spim_top
   import spim_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 32,
   parameter int PRE_LO      = 16,
   parameter int PRE_HI      = 128,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic              bus_re,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              sck,
   output logic              mosi,
   input  logic              miso,
   output logic              cs_n
);

   ctrl_t                 ctrl;
   logic                  start;
   logic                  busy;
   logic                  done;
   logic                  tick;
   logic                  rxf;
   logic                  cpol;
   logic [FRAME_BITS-1:0] tx_byte;
   logic [FRAME_BITS-1:0] rx_word;
   logic [FRAME_BITS-1:0] tx_load;

   assign cpol    = ctrl.cpol;
   assign tx_load = start ? bus_wdata[FRAME_BITS-1:0] : tx_byte;

   spim_regfile #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .bus_re    (bus_re),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .busy      (busy),
      .done      (done),
      .rx_word   (rx_word),
      .ctrl      (ctrl),
      .start     (start),
      .tx_byte   (tx_byte),
      .rxf       (rxf),
      .cs_n      (cs_n)
   );

   spim_baud #(
      .PRE_LO (PRE_LO),
      .PRE_HI (PRE_HI)
   ) u_baud (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .run   (busy),
      .slow  (ctrl.slow),
      .div   (ctrl.div),
      .tick  (tick)
   );

   spim_shifter #(
      .SYNC_STAGES (SYNC_STAGES)
   ) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .tx_byte (tx_load),
      .cpol    (cpol),
      .cpha    (ctrl.cpha),
      .tick    (tick),
      .miso    (miso),
      .busy    (busy),
      .done    (done),
      .sck     (sck),
      .mosi    (mosi),
      .rx_word (rx_word)
   );

endmodule

// File: rtl/spim_chk.sv
module spim_chk
   import spim_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_we,
   input logic              bus_re,
   input logic              wd_cs,
   input logic              wd_rxf,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              sck,
   input logic              cs_n,
   input logic              busy,
   input logic              done,
   input logic              rxf,
   input logic              cpol
);

   logic mapped;
   assign mapped = (bus_addr == ADDR_W'(OFS_CTRL)) || (bus_addr == ADDR_W'(OFS_STAT)) ||
                   (bus_addr == ADDR_W'(OFS_SYS))  || (bus_addr == ADDR_W'(OFS_TXB))  ||
                   (bus_addr == ADDR_W'(OFS_RXB))  || (bus_addr == ADDR_W'(OFS_AUX));

   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !mapped |-> bus_rdata == '0); // R2

   AST_SCK_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> sck == cpol); // R4

   AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !done |=> busy); // R5

   AST_FRAME_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy); // R5

   AST_RXF_SET_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> rxf); // R6

   AST_RXF_CLR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      bus_re && bus_addr == ADDR_W'(OFS_RXB) && !done |=> !rxf); // R7

   AST_STAT_WRITE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      bus_we && bus_addr == ADDR_W'(OFS_STAT) && !wd_rxf && !done |=> !rxf); // R8

   AST_CS_TRACKS_SYS: assert property (@(posedge clk) disable iff (!rst_n)
      bus_we && bus_addr == ADDR_W'(OFS_SYS) |=> cs_n == $past(wd_cs)); // R9

endmodule

bind spim_top spim_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_we    (bus_we),
   .bus_re    (bus_re),
   .wd_cs     (bus_wdata[6]),
   .wd_rxf    (bus_wdata[2]),
   .bus_rdata (bus_rdata),
   .sck       (sck),
   .cs_n      (cs_n),
   .busy      (busy),
   .done      (done),
   .rxf       (rxf),
   .cpol      (cpol)
);

// File: tb/spim_top_bench.sv
`timescale 1ns/1ps
module spim_top_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic        bus_re = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        sck, mosi, cs_n;
   logic        miso = 1'b0;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   spim_top u_spim_top (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .bus_re    (bus_re),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .sck       (sck),
      .mosi      (mosi),
      .miso      (miso),
      .cs_n      (cs_n)
   );

   // behavioural slave
   bit         slave_on = 1'b0;
   logic       m_cpol = 1'b0;
   logic       m_cpha = 1'b0;
   logic [7:0] s_tx = '0;
   logic [7:0] s_rx = '0;
   int         s_idx = 0;
   int         s_edges = 0;
   longint     t_prev = 0;
   longint     t_last = 0;

   always @(sck) begin
      if (slave_on) begin
         automatic logic lead = (sck != m_cpol);
         s_edges++;
         t_prev = t_last;
         t_last = longint'($time);
         if (lead ^ m_cpha) begin
            s_rx = {s_rx[6:0], mosi};
         end else if (s_idx < 8) begin
            miso = s_tx[7 - s_idx];
            s_idx++;
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a; bus_re = 1'b1;
      #1 d = bus_rdata;
      @(posedge clk);
      @(negedge clk);
      bus_re = 1'b0;
   endtask

   task automatic wait_idle();
      logic [31:0] st;
      for (int i = 0; i < 5000; i++) begin
         rd(8'h04, st);
         if (st[0] == 1'b0) break;
      end
   endtask

   task automatic prep(input logic cpha, input logic cpol, input logic slow,
                       input logic [4:0] n, input logic [7:0] stx);
      wr(8'h00, {24'h0, cpha, cpol, slow, n});
      m_cpol = cpol; m_cpha = cpha;
      s_tx = stx; s_rx = '0; s_edges = 0; t_prev = 0; t_last = 0;
      if (cpha) begin s_idx = 0; end
      else begin miso = stx[7]; s_idx = 1; end
      slave_on = 1'b1;
   endtask

   // full exchange with timing and data checks
   task automatic t_xfer(input string tag, input logic cpha, input logic cpol,
                         input logic slow, input logic [4:0] n,
                         input logic [7:0] tx, input logic [7:0] stx, input bit do_read);
      logic [31:0] d;
      longint half;
      half = (slow ? 128 : 16) * (longint'(n) + 1) * 10;
      prep(cpha, cpol, slow, n, stx);
      wr(8'h0C, {24'h0, tx});
      rd(8'h04, d);
      chk({tag, " R5 busy after start"}, d[0], 1'b1);
      wait_idle();
      slave_on = 1'b0;
      chk({tag, " R3 edge count"}, s_edges, 16);
      chk({tag, " R3 half period ns"}, 32'(t_last - t_prev), 32'(half));
      chk({tag, " R4 mosi byte at slave"}, s_rx, tx);
      chk({tag, " R4 sck idle level"}, sck, cpol);
      rd(8'h04, d);
      chk({tag, " R6 rx full"}, d[2], 1'b1);
      if (do_read) begin
         rd(8'h10, d);
         chk({tag, " R6 rx byte"}, d, {24'h0, stx});
         rd(8'h04, d);
         chk({tag, " R7 rx full cleared by read"}, d[2], 1'b0);
      end
   endtask

   task automatic t_reset();
      logic [31:0] d;
      rd(8'h00, d); chk("R1 ctrl reset", d, 32'h0);
      rd(8'h04, d); chk("R1 status reset", d, 32'h0);
      rd(8'h08, d); chk("R1 sysctl reset", d, 32'h40);
      rd(8'h0C, d); chk("R1 tx reset", d, 32'h0);
      rd(8'h10, d); chk("R1 rx reset", d, 32'h0);
      rd(8'h14, d); chk("R1 scratch reset", d, 32'h0);
      chk("R1 cs_n reset", cs_n, 1'b1);
      chk("R1 sck reset", sck, 1'b0);
   endtask

   task automatic t_map();
      logic [31:0] d;
      wr(8'h14, 32'hDEADBEEF);
      rd(8'h14, d); chk("R2 scratch readback", d, 32'hDEADBEEF);
      chk("R2 scratch no effect on cs_n", cs_n, 1'b1);
      rd(8'h18, d); chk("R2 unmapped 0x18", d, 32'h0);
      rd(8'h01, d); chk("R2 unmapped 0x01", d, 32'h0);
      wr(8'h00, 32'h0000_00A5);
      rd(8'h00, d); chk("R2 ctrl readback", d, 32'hA5);
      wr(8'h00, 32'h0);
   endtask

   task automatic t_cpol_idle();
      wr(8'h00, 32'h40);
      chk("R4 idle sck high with cpol", sck, 1'b1);
      wr(8'h00, 32'h00);
      chk("R4 idle sck low without cpol", sck, 1'b0);
   endtask

   task automatic t_busy_write();
      logic [31:0] d;
      prep(1'b0, 1'b0, 1'b0, 5'd0, 8'h5A);
      wr(8'h0C, 32'hA5);
      repeat (40) @(negedge clk);
      wr(8'h0C, 32'h3C);
      rd(8'h0C, d);
      chk("R5 tx readback during frame", d, 32'hA5);
      wait_idle();
      slave_on = 1'b0;
      chk("R5 ignored write edge count", s_edges, 16);
      chk("R5 ignored write byte at slave", s_rx, 8'hA5);
      rd(8'h10, d);
      chk("R6 rx byte after ignored write", d, 32'h5A);
   endtask

   task automatic t_overwrite();
      logic [31:0] d;
      t_xfer("ovr1", 1'b0, 1'b0, 1'b0, 5'd0, 8'h0F, 8'h11, 1'b0);
      t_xfer("ovr2", 1'b1, 1'b0, 1'b0, 5'd0, 8'hF0, 8'h77, 1'b0);
      rd(8'h10, d);
      chk("R7 overwrite keeps newest byte", d, 32'h77);
   endtask

   task automatic t_status_clear();
      logic [31:0] d;
      t_xfer("sclr", 1'b0, 1'b1, 1'b0, 5'd0, 8'h81, 8'h18, 1'b0);
      wr(8'h04, 32'h4);
      rd(8'h04, d); chk("R8 status write bit2=1 keeps flag", d[2], 1'b1);
      wr(8'h04, 32'h0);
      rd(8'h04, d); chk("R8 status write 0 clears flag", d[2], 1'b0);
   endtask

   task automatic t_cs();
      wr(8'h08, 32'h00); chk("R9 cs_n low", cs_n, 1'b0);
      wr(8'h08, 32'h40); chk("R9 cs_n high", cs_n, 1'b1);
      wr(8'h08, 32'h21); chk("R9 cs_n low after 0x21", cs_n, 1'b0);
      wr(8'h08, 32'hBF); chk("R9 other bits leave cs_n low", cs_n, 1'b0);
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog expired actual=running expected=done");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_map();
      t_cpol_idle();
      t_cs();
      t_xfer("mode0", 1'b0, 1'b0, 1'b0, 5'd0, 8'hA5, 8'h3C, 1'b1);
      t_xfer("mode1", 1'b1, 1'b0, 1'b0, 5'd1, 8'h96, 8'hC3, 1'b1);
      t_xfer("mode2", 1'b0, 1'b1, 1'b0, 5'd3, 8'h01, 8'h80, 1'b1);
      t_xfer("mode3", 1'b1, 1'b1, 1'b0, 5'd2, 8'hE7, 8'h5B, 1'b1);
      t_xfer("slow", 1'b0, 1'b0, 1'b1, 5'd0, 8'h6D, 8'h92, 1'b1);
      t_busy_write();
      t_overwrite();
      t_status_clear();
      finished = 1'b1;
      summary();
      $finish;
   end

endmodule